// File: doc/BRIEF.md
# Paged Single-Channel Byte DMA Controller

This block moves bytes, one at a time, between a single peripheral and system memory. The peripheral raises a request line. While software has armed the channel and bytes remain, the engine forms a physical address and performs one memory access through a valid/ready master port. It then pulses an acknowledge to the peripheral, which either supplies or takes the data byte. The byte direction is chosen by a control bit.

Physical addresses are paged. A 128-entry table, filled by software, holds a 20-bit page frame for each logical page. The low seven bits of a running page tag select the entry, and a 12-bit in-page offset supplies the low address bits. When the offset passes the end of a page, the tag moves on to the next logical page.

Software programs the channel through a 32-bit slave register port. The word offsets are: control at 0x00, status at 0x04, count at 0x08, tag at 0x0C, offset at 0x10, and a page-table write port at 0x14. Software writes the table, tag, offset and count, then sets the enable bit. It waits for the interrupt, which is raised when the count reaches zero. An end-of-process output marks the final byte for the peripheral.

Top module: `paged_byte_dma`

## Requirements
- R1: Registers are selected by s_addr[4:2]. Word 0 (byte offset 0x00) is control (write). Word 1 (0x04) is status (read). Word 2 (0x08) is count. Word 3 (0x0C) is tag. Word 4 (0x10) is offset. Word 5 (0x14) writes the page-table entry indexed by tag[6:0] with s_wdata[19:0]. A status read returns enable at bit 0, direction at bit 1, zero at bit 2, interrupt at bit 3 and terminal-count at bit 4, with bits 31:5 zero. A read of any other word returns zero.
- R2: A control write with bit 2 set clears status, count, tag and offset, and drops end-of-process. The page table is left unchanged.
- R3: Hardware reset (rst_n low at a clock edge) clears all registers and every page-table entry. After reset, irq, eop and m_valid are low.
- R4: A control write with bit 2 clear loads enable from bit 0 and direction from bit 1, and clears the interrupt and terminal-count flags.
- R5: A byte transfer starts only while p_req is high, enable is set and the count is nonzero. With any of these missing, no memory request is made.
- R6: The memory address of each byte is the table entry at tag[6:0] shifted left by 12, ORed with offset[11:0].
- R7: With direction 1, the byte sampled from p_rdata during the one-cycle p_ack pulse is written to memory (m_write high). With direction 0, the byte read from memory (m_write low) is presented on p_wdata during the one-cycle p_ack pulse.
- R8: After each byte, the offset increments. If offset[11:0] was 0xFFF, the offset becomes 0 and the tag increments instead. The count then decreases by one.
- R9: eop is high from the start of the memory access of a byte that began with count 1 until that byte completes. It is low for all other bytes and after completion.
- R10: When the count reaches zero, enable clears and both the interrupt and terminal-count flags set. irq follows the interrupt flag.
- R11: m_valid, once raised, stays high with a stable m_addr until m_ready is seen, and each handshake moves exactly one byte. A control write that clears enable stops the engine, and no further byte is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_sel | input | 1 | Register port access strobe |
| s_wr | input | 1 | Register port write (1) or read (0) |
| s_addr | input | 5 | Register byte address |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data (combinational) |
| p_req | input | 1 | Peripheral transfer request |
| p_ack | output | 1 | Peripheral acknowledge pulse |
| p_rdata | input | 8 | Byte from the peripheral |
| p_wdata | output | 8 | Byte to the peripheral |
| m_valid | output | 1 | Memory request valid |
| m_write | output | 1 | Memory request is a write |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 8 | Memory write byte |
| m_rdata | input | 8 | Memory read byte, valid with m_ready |
| m_ready | input | 1 | Memory accepts or completes the request |
| eop | output | 1 | End-of-process marker for the final byte |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The checks on request ordering and address formation assume that software leaves count, tag and offset alone while a byte is in flight. They also assume that the memory side raises m_ready only in response to m_valid. The stimulus rewrites those registers only while the request line is low or after a stop. Its memory model answers a pending request after a per-test number of wait cycles, from zero to three. Stopping is done only through a control write, which the checks treat as a legal way to drop a pending memory request.

// File: rtl/pbd_pkg.sv
// Shared constants and types for the paged byte DMA controller.
// Assumes a 32-bit register port addressed in bytes, decoded on word boundaries.
package pbd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REG_W   = 32;
    localparam int BUS_AW  = 5;
    localparam int WSEL_W  = BUS_AW - 2;

    // Word selects of the register port
    localparam logic [WSEL_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [WSEL_W-1:0] RA_STAT  = 3'd1;
    localparam logic [WSEL_W-1:0] RA_COUNT = 3'd2;
    localparam logic [WSEL_W-1:0] RA_TAG   = 3'd3;
    localparam logic [WSEL_W-1:0] RA_OFFS  = 3'd4;
    localparam logic [WSEL_W-1:0] RA_MAP   = 3'd5;

    // Control and status bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_SRST = 2;
    localparam int BIT_IRQ  = 3;
    localparam int BIT_TC   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_XFER,
        ST_UPDATE
    } eng_state_e;

    typedef struct packed {
        logic tc;
        logic irq;
        logic dir;
        logic en;
    } flags_t;
endpackage

// File: rtl/pbd_page_map.sv
// Page-frame table: DEPTH entries of FRAME_W bits, one synchronous write port
// and one combinational read port. Assumes hardware reset is the only clear.
module pbd_page_map #(
    parameter int DEPTH   = 128,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [FRAME_W-1:0] wdata,
    input  logic [IDX_W-1:0]   ridx,
    output logic [FRAME_W-1:0] rframe
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [FRAME_W-1:0] frames [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Holds one frame; cleared only by hardware reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frames[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                frames[g] <= wdata;
            end
        end
    end

    // Read the frame for the current page tag
    assign rframe = frames[ridx];
endmodule

// File: rtl/pbd_regs.sv
// Register file: control/status flags, byte count, page tag and in-page
// offset, plus decode of the table write port. Applies per-byte pointer
// updates requested by the engine. Assumes single-cycle register accesses.
module pbd_regs
    import pbd_pkg::*;
#(
    parameter int FRAME_W   = 20,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_sel,
    input  logic               s_wr,
    input  logic [BUS_AW-1:0]  s_addr,
    input  logic [REG_W-1:0]   s_wdata,
    output logic [REG_W-1:0]   s_rdata,
    input  logic               step,
    output flags_t             flags_q,
    output logic [REG_W-1:0]   count_q,
    output logic [REG_W-1:0]   tag_q,
    output logic [REG_W-1:0]   off_q,
    output logic               map_we,
    output logic [FRAME_W-1:0] map_wdata,
    output logic [IDX_W-1:0]   map_idx,
    output logic               abort,
    output logic               can_run,
    output logic               last_byte
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WSEL_W-1:0] wsel;
    logic              wr;
    logic              ctrl_wr;
    logic              soft_rst;
    logic              page_end;
    logic [REG_W-1:0]  stat_word;

    // Decode register strobes
    assign wsel      = s_addr[BUS_AW-1:2];
    assign wr        = s_sel && s_wr;
    assign ctrl_wr   = wr && (wsel == RA_CTRL);
    assign soft_rst  = ctrl_wr && s_wdata[BIT_SRST];
    assign abort     = soft_rst || (ctrl_wr && !s_wdata[BIT_EN]);
    assign map_we    = wr && (wsel == RA_MAP);
    assign map_wdata = s_wdata[FRAME_W-1:0];
    assign map_idx   = tag_q[IDX_W-1:0];
    assign page_end  = (off_q[PAGE_BITS-1:0] == {PAGE_BITS{1'b1}});
    assign last_byte = (count_q == REG_W'(1));
    assign can_run   = flags_q.en && (count_q != '0);

    // Control and status flags
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            flags_q <= '0;
        end else if (ctrl_wr) begin
            flags_q.en  <= s_wdata[BIT_EN];
            flags_q.dir <= s_wdata[BIT_DIR];
            flags_q.irq <= 1'b0;
            flags_q.tc  <= 1'b0;
        end else if (step && last_byte) begin
            flags_q.en  <= 1'b0;
            flags_q.irq <= 1'b1;
            flags_q.tc  <= 1'b1;
        end
    end

    // Remaining byte count
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            count_q <= '0;
        end else if (wr && (wsel == RA_COUNT)) begin
            count_q <= s_wdata;
        end else if (step) begin
            count_q <= count_q - REG_W'(1);
        end
    end

    // Logical page tag, advanced on page wrap
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tag_q <= '0;
        end else if (wr && (wsel == RA_TAG)) begin
            tag_q <= s_wdata;
        end else if (step && page_end) begin
            tag_q <= tag_q + REG_W'(1);
        end
    end

    // In-page offset, restarted at a page wrap
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            off_q <= '0;
        end else if (wr && (wsel == RA_OFFS)) begin
            off_q <= s_wdata;
        end else if (step) begin
            off_q <= page_end ? '0 : off_q + REG_W'(1);
        end
    end

    // Status word and read mux
    always_comb begin
        stat_word           = '0;
        stat_word[BIT_EN]   = flags_q.en;
        stat_word[BIT_DIR]  = flags_q.dir;
        stat_word[BIT_IRQ]  = flags_q.irq;
        stat_word[BIT_TC]   = flags_q.tc;
        s_rdata = (s_sel && !s_wr && (wsel == RA_STAT)) ? stat_word : '0;
    end
endmodule

// File: rtl/pbd_engine.sv
// Byte transfer sequencer: IDLE -> ADDR -> XFER -> UPDATE, one byte per pass.
// ADDR latches the physical address (and the peripheral byte when moving
// into memory), XFER holds the memory request until ready, UPDATE hands the
// byte to the peripheral when reading memory and advances the pointers.
// Assumes abort may arrive in any state and returns to IDLE at once.
module pbd_engine #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int DATA_W    = 8,
    localparam int FRAME_W  = ADDR_W - PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 can_run,
    input  logic                 dir,
    input  logic                 last_byte,
    input  logic [FRAME_W-1:0]   frame,
    input  logic [PAGE_BITS-1:0] off_low,
    input  logic                 p_req,
    input  logic [DATA_W-1:0]    p_rdata,
    input  logic                 m_ready,
    input  logic [DATA_W-1:0]    m_rdata,
    output logic                 step,
    output logic                 busy,
    output logic                 p_ack,
    output logic [DATA_W-1:0]    p_wdata,
    output logic                 m_valid,
    output logic                 m_write,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [DATA_W-1:0]    m_wdata,
    output logic                 eop
);
    timeunit 1ns;
    timeprecision 1ps;
    import pbd_pkg::*;

    eng_state_e          state_q;
    eng_state_e          state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                eop_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (p_req && can_run) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_XFER;
            ST_XFER:   if (m_ready) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address and data capture for the byte in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_ADDR) begin
            addr_q <= {frame, off_low};
            if (dir) data_q <= p_rdata;
        end else if ((state_q == ST_XFER) && m_ready && !dir) begin
            data_q <= m_rdata;
        end
    end

    // End-of-process marker for the final byte
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            eop_q <= 1'b0;
        end else if (state_q == ST_ADDR) begin
            eop_q <= last_byte;
        end else if (state_q == ST_UPDATE) begin
            eop_q <= 1'b0;
        end
    end

    // Output strobes
    assign step    = (state_q == ST_UPDATE) && !abort;
    assign busy    = (state_q != ST_IDLE);
    assign p_ack   = !abort && (((state_q == ST_ADDR) && dir) ||
                                ((state_q == ST_UPDATE) && !dir));
    assign p_wdata = data_q;
    assign m_valid = (state_q == ST_XFER);
    assign m_write = dir;
    assign m_addr  = addr_q;
    assign m_wdata = data_q;
    assign eop     = eop_q;
endmodule

// File: rtl/paged_byte_dma.sv
// Top of the paged single-channel byte DMA controller: register file,
// page-frame table and transfer sequencer. Assumes one peripheral and one
// memory master port; no arbitration is done here.
module paged_byte_dma #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int MAP_DEPTH = 128,
    parameter int DATA_W    = 8,
    localparam int FRAME_W  = ADDR_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(MAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_wr,
    input  logic [4:0]        s_addr,
    input  logic [31:0]       s_wdata,
    output logic [31:0]       s_rdata,
    input  logic              p_req,
    output logic              p_ack,
    input  logic [DATA_W-1:0] p_rdata,
    output logic [DATA_W-1:0] p_wdata,
    output logic              m_valid,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    output logic              eop,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;
    import pbd_pkg::*;

    flags_t             flags_q;
    logic [REG_W-1:0]   count_q;
    logic [REG_W-1:0]   tag_q;
    logic [REG_W-1:0]   off_q;
    logic               map_we;
    logic [FRAME_W-1:0] map_wdata;
    logic [IDX_W-1:0]   map_idx;
    logic [FRAME_W-1:0] frame;
    logic               abort_w;
    logic               can_run;
    logic               last_byte;
    logic               step;
    logic               busy_w;

    pbd_regs #(
        .FRAME_W  (FRAME_W),
        .PAGE_BITS(PAGE_BITS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_sel    (s_sel),
        .s_wr     (s_wr),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_rdata  (s_rdata),
        .step     (step),
        .flags_q  (flags_q),
        .count_q  (count_q),
        .tag_q    (tag_q),
        .off_q    (off_q),
        .map_we   (map_we),
        .map_wdata(map_wdata),
        .map_idx  (map_idx),
        .abort    (abort_w),
        .can_run  (can_run),
        .last_byte(last_byte)
    );

    pbd_page_map #(
        .DEPTH  (MAP_DEPTH),
        .FRAME_W(FRAME_W)
    ) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .widx  (map_idx),
        .wdata (map_wdata),
        .ridx  (map_idx),
        .rframe(frame)
    );

    pbd_engine #(
        .ADDR_W   (ADDR_W),
        .PAGE_BITS(PAGE_BITS),
        .DATA_W   (DATA_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort_w),
        .can_run  (can_run),
        .dir      (flags_q.dir),
        .last_byte(last_byte),
        .frame    (frame),
        .off_low  (off_q[PAGE_BITS-1:0]),
        .p_req    (p_req),
        .p_rdata  (p_rdata),
        .m_ready  (m_ready),
        .m_rdata  (m_rdata),
        .step     (step),
        .busy     (busy_w),
        .p_ack    (p_ack),
        .p_wdata  (p_wdata),
        .m_valid  (m_valid),
        .m_write  (m_write),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .eop      (eop)
    );

    // Interrupt output follows the status flag
    assign irq = flags_q.irq;
endmodule

// File: rtl/pbd_checker.sv
// Protocol and sequencing properties for paged_byte_dma, attached by bind.
// Assumes software does not rewrite count, tag or offset mid-byte.
module pbd_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 abort,
    input logic                 busy,
    input logic                 can_run,
    input logic                 en,
    input logic                 tc,
    input logic                 irq,
    input logic                 eop,
    input logic                 p_ack,
    input logic                 m_valid,
    input logic                 m_ready,
    input logic [ADDR_W-1:0]    m_addr,
    input logic [PAGE_BITS-1:0] off_low
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !abort) |=> (m_valid && $stable(m_addr))); // R11

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> can_run); // R5

    AST_ADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> (m_addr[PAGE_BITS-1:0] == off_low)); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        p_ack |=> !p_ack); // R7

    AST_EOP_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> busy); // R9

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (tc && !en)); // R10
endmodule

bind paged_byte_dma pbd_checker #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (abort_w),
    .busy   (busy_w),
    .can_run(can_run),
    .en     (flags_q.en),
    .tc     (flags_q.tc),
    .irq    (irq),
    .eop    (eop),
    .p_ack  (p_ack),
    .m_valid(m_valid),
    .m_ready(m_ready),
    .m_addr (m_addr),
    .off_low(off_q[PAGE_BITS-1:0])
);

// File: tb/test_paged_byte_dma.sv
// Self-checking bench: a vector table of complete transfers, then directed
// tests for reset, gating, stop, soft reset and hardware reset.
module test_paged_byte_dma;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_COUNT = 5'h08,
                           A_TAG = 5'h0C, A_OFFS = 5'h10, A_MAP = 5'h14;

    typedef struct packed {
        logic        dir;
        logic [31:0] tag;
        logic [31:0] off;
        logic [31:0] cnt;
        logic [19:0] fa;
        logic [19:0] fb;
        logic [3:0]  lat;
        logic [31:0] first;
        logic [31:0] last;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h5,   32'h10,   32'd4, 20'h12345, 20'h00000, 4'd0, 32'h12345010, 32'h12345013},
        '{1'b1, 32'h7F,  32'hFFE,  32'd3, 20'hABCDE, 20'h00777, 4'd2, 32'hABCDEFFE, 32'h00777000},
        '{1'b0, 32'h283, 32'h5FFF, 32'd2, 20'h0F0F0, 20'h11111, 4'd1, 32'h0F0F0FFF, 32'h11111000},
        '{1'b1, 32'h9,   32'h0,    32'd1, 20'hFFFFF, 20'h00000, 4'd3, 32'hFFFFF000, 32'hFFFFF000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_sel = 1'b0, s_wr = 1'b0;
    logic [4:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic        p_req = 1'b0;
    logic        p_ack;
    logic [7:0]  p_rdata = 8'h40;
    logic [7:0]  p_wdata;
    logic        m_valid, m_write;
    logic [31:0] m_addr;
    logic [7:0]  m_wdata;
    logic [7:0]  m_rdata;
    logic        m_ready = 1'b0;
    logic        eop, irq;

    int          tests = 0, fails = 0;
    int          hs_cnt = 0, ack_cnt = 0, data_err = 0, eop_hits = 0, wcnt = 0;
    int          lat = 0;
    logic        cur_dir = 1'b0, last_eop = 1'b0;
    logic [31:0] first_addr = '0, last_addr = '0;
    logic [7:0]  last_rd = '0;

    paged_byte_dma i_paged_byte_dma (
        .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .p_req(p_req), .p_ack(p_ack),
        .p_rdata(p_rdata), .p_wdata(p_wdata), .m_valid(m_valid), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
        .eop(eop), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[19:12] ^ 8'h3C;
    endfunction

    assign m_rdata = pat(m_addr);

    // Memory responder and transfer monitor, evaluated mid-cycle
    always @(negedge clk) begin
        if (p_ack) begin
            ack_cnt++;
            if (!cur_dir && (p_wdata !== last_rd)) data_err++;
        end
        if (m_ready) begin
            m_ready = 1'b0;
            wcnt = 0;
        end else if (m_valid) begin
            if (wcnt >= lat) begin
                hs_cnt++;
                if (hs_cnt == 1) first_addr = m_addr;
                last_addr = m_addr;
                if (m_write !== cur_dir) data_err++;
                if (m_write) begin
                    if (m_wdata !== p_rdata) data_err++;
                    p_rdata = p_rdata + 8'h11;
                end else begin
                    last_rd = pat(m_addr);
                end
                if (eop) eop_hits++;
                last_eop = eop;
                m_ready = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_sel = 1'b0; s_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_wr = 1'b0; s_addr = a;
        #1 d = s_rdata;
        s_sel = 1'b0;
    endtask

    task automatic clear_mon();
        hs_cnt = 0; ack_cnt = 0; data_err = 0; eop_hits = 0; last_eop = 1'b0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 400 && !irq; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R3, R1)
        bus_rd(A_STAT, rd);
        chk("R3", "status after reset", rd, 32'h0);
        chk("R3", "outputs after reset", {29'b0, irq, eop, m_valid}, 32'h0);

        // Vector table of complete transfers (R6 R7 R8 R9 R10)
        for (int v = 0; v < NVEC; v++) begin
            cur_dir = VECS[v].dir;
            lat     = int'(VECS[v].lat);
            clear_mon();
            bus_wr(A_TAG, VECS[v].tag);
            bus_wr(A_MAP, {12'b0, VECS[v].fa});
            bus_wr(A_TAG, VECS[v].tag + 32'd1);
            bus_wr(A_MAP, {12'b0, VECS[v].fb});
            bus_wr(A_TAG, VECS[v].tag);
            bus_wr(A_OFFS, VECS[v].off);
            bus_wr(A_COUNT, VECS[v].cnt);
            p_req = 1'b1;
            bus_wr(A_CTRL, {30'b0, VECS[v].dir, 1'b1});
            wait_irq();
            p_req = 1'b0;
            repeat (2) @(negedge clk);
            chk("R11", "byte count", hs_cnt, VECS[v].cnt);
            chk("R6", "first address", first_addr, VECS[v].first);
            chk("R8", "last address after page advance", last_addr, VECS[v].last);
            chk("R7", "data path and direction errors", data_err, 32'd0);
            chk("R7", "acknowledge pulses", ack_cnt, VECS[v].cnt);
            chk("R9", "eop on final byte only", {eop_hits[30:0], last_eop}, 32'h3);
            chk("R9", "eop low after completion", {31'b0, eop}, 32'h0);
            bus_rd(A_STAT, rd);
            chk("R10", "status on completion", rd, {27'b0, 2'b11, 1'b0, VECS[v].dir, 1'b0});
            chk("R10", "irq on completion", {31'b0, irq}, 32'h1);
        end

        // Control write clears flags (R4); other words read zero (R1)
        bus_wr(A_CTRL, 32'h2);
        bus_rd(A_STAT, rd);
        chk("R4", "flags cleared, direction kept", rd, 32'h2);
        chk("R4", "irq cleared", {31'b0, irq}, 32'h0);
        bus_rd(A_COUNT, rd);
        chk("R1", "non-status read", rd, 32'h0);

        // Request gating (R5)
        cur_dir = 1'b0; lat = 0; clear_mon();
        bus_wr(A_TAG, 32'h5); bus_wr(A_OFFS, 32'h0); bus_wr(A_COUNT, 32'd3);
        bus_wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        chk("R5", "no transfer without request", hs_cnt, 32'd0);
        bus_rd(A_STAT, rd);
        chk("R5", "armed status", rd, 32'h1);
        p_req = 1'b1;
        wait_irq();
        repeat (2) @(negedge clk);
        chk("R5", "transfers once requested", hs_cnt, 32'd3);

        // Stop by clearing enable (R11)
        clear_mon(); lat = 3;
        bus_wr(A_COUNT, 32'd10);
        bus_wr(A_CTRL, 32'h1);
        for (int k = 0; k < 400 && hs_cnt < 3; k++) @(negedge clk);
        bus_wr(A_CTRL, 32'h0);
        @(negedge clk);
        snap = hs_cnt;
        repeat (30) @(negedge clk);
        chk("R11", "no byte after stop", hs_cnt, snap);
        bus_rd(A_STAT, rd);
        chk("R11", "status after stop", rd, 32'h0);
        chk("R11", "eop after stop", {31'b0, eop}, 32'h0);

        // Soft reset (R2)
        p_req = 1'b0; lat = 0;
        bus_wr(A_TAG, 32'h55); bus_wr(A_OFFS, 32'h123); bus_wr(A_COUNT, 32'd5);
        bus_wr(A_CTRL, 32'h3);
        bus_wr(A_CTRL, 32'h4);
        bus_rd(A_STAT, rd);
        chk("R2", "status after soft reset", rd, 32'h0);
        clear_mon(); cur_dir = 1'b0;
        p_req = 1'b1;
        bus_wr(A_CTRL, 32'h1);
        repeat (20) @(negedge clk);
        chk("R2", "count cleared by soft reset", hs_cnt, 32'd0);
        bus_wr(A_COUNT, 32'd1);
        wait_irq();
        repeat (2) @(negedge clk);
        chk("R2", "tag/offset cleared, table kept", last_addr, 32'h00777000);

        // Hardware reset clears the table (R3)
        p_req = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        bus_rd(A_STAT, rd);
        chk("R3", "status after hardware reset", rd, 32'h0);
        chk("R3", "outputs after hardware reset", {29'b0, irq, eop, m_valid}, 32'h0);
        clear_mon();
        bus_wr(A_TAG, 32'h5); bus_wr(A_OFFS, 32'h10); bus_wr(A_COUNT, 32'd1);
        p_req = 1'b1;
        bus_wr(A_CTRL, 32'h1);
        wait_irq();
        repeat (2) @(negedge clk);
        chk("R3", "table cleared by hardware reset", last_addr, 32'h00000010);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule